// File: doc/BRIEF.md
# Cascadable Serial Result Port

This block is the device-side read port for a converter result. A sequencer presents a 24-bit two's-complement word together with a one-cycle load strobe and a data-ready level. The port holds that word in a shift register and sends it out most significant bit first. A host reads it through a chip select, a serial clock and a data line. The pins from the host are asynchronous to the block, so the port samples chip select, serial clock and serial data input in its own fast system clock. It reacts to falling edges of the serial clock that it detects there.

Two read styles are supported. In the first, the host drops chip select after data-ready has gone low, and the first bit shows as soon as the select is seen. In the second, chip select stays low all the time, and the first bit shows as soon as the new word is loaded, which coincides with data-ready falling. The output-enable flag stands in for the tristate buffer. It is low whenever chip select is high, so several ports can share one line.

For cascading, the serial input enters at the low end of the shift register. When the output of one port feeds the input of the next port upstream, the upstream pin carries its own word first, then the words of the ports further down the chain in order, then zeros from the last port, whose input is tied low.

Top module: `chain_sout_port`

## Requirements
- R1: The word is 24 bits wide and leaves MSB first. Each accepted serial-clock falling edge moves the register up by exactly one place, so the output shows the next lower bit.
- R2: With a word loaded and data-ready low, a chip-select falling edge makes `sdo_oe` go high and `sdo` show bit 23 of the word. This happens after the second rising clock edge following the pin change.
- R3: With chip select held low, `sdo` shows bit 23 of a newly loaded word from the clock cycle right after the load strobe.
- R4: After reset, `sdo_oe` and `sdo` are 0 and the shift register holds all zeros.
- R5: While chip select is seen high, `sdo_oe` is 0 and `sdo` is 0. Both follow the chip-select pin two rising clock edges later.
- R6: On every accepted shift, the serial input enters bit 0. It is sampled at the same clock edge at which the serial-clock fall is first seen. With two ports cascaded, the upstream pin carries the upstream word and then the downstream word.
- R7: At the end of a chain whose last input is low, more than 24×K shifts give a `sdo` of 0.
- R8: A serial-clock falling edge that is acted on while `drdy_n` is high leaves the register unchanged.
- R9: A serial-clock falling edge seen while chip select is high leaves the register unchanged.
- R10: A load strobe replaces the whole register with the new word and discards partly shifted contents. It takes priority over a shift in the same cycle.
- R11: A serial-clock falling edge present on the pin before rising clock edge n is first seen at edge n. The shift takes effect at edge n+2, so the new bit is visible after the third rising edge following the pin change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, fast relative to the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select from the host, active low, asynchronous |
| sclk | input | 1 | Serial clock from the host, idles high, asynchronous |
| sdi | input | 1 | Serial input from the next port down the chain |
| drdy_n | input | 1 | Data-ready level from the sequencer, low while reading is allowed |
| load | input | 1 | One-cycle strobe that loads `load_word` |
| load_word | input | 24 | Converter result, two's complement |
| sdo | output | 1 | Serial data out, 0 while not enabled |
| sdo_oe | output | 1 | Output enable standing in for the tristate buffer |

## Verification
The bench goes after the delay from the pins into the system-clock domain. If the delay were off by one cycle, a cascaded port would capture the downstream bit after that bit had already moved, and the downstream word would arrive shifted or doubled. It reloads a word partway through a read, so a design that only cleared a bit counter and not the register would leak old bits into the new read. It sends serial-clock falls while data-ready is high and while chip select is high, so a design that does not gate these would lose leading bits of the next read. It also reads past the end of a two-port chain, and any output other than zeros there shows a shift that wraps around or fills from the wrong end.

// File: rtl/sop_pkg.sv
package sop_pkg;

  // Host-side pins carried together through the synchronizer.
  typedef struct packed {
    logic cs_n;
    logic sclk;
    logic sdi;
  } pin_t;

  localparam int PIN_W = $bits(pin_t);

  // Value the synchronized pins take in reset: deselected, clock idle high.
  localparam pin_t PIN_IDLE = '{cs_n: 1'b1, sclk: 1'b1, sdi: 1'b0};

endpackage

// File: rtl/sop_rst_sync.sv
module sop_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q <= 2'b00;
    end else begin
      rst_q <= {rst_q[0], 1'b1};
    end
  end

  assign rst_sync_n = rst_q[1];

endmodule

// File: rtl/sop_sync.sv
module sop_sync #(
  parameter int              W       = 1,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      logic [W-1:0] stg_d;
      if (s == 0) begin : g_first
        assign stg_d = d;
      end else begin : g_next
        assign stg_d = stg_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stg_q[s] <= RST_VAL;
        end else begin
          stg_q[s] <= stg_d;
        end
      end
    end
  endgenerate

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/sop_fall_det.sv
module sop_fall_det (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic fall
);

  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
    end else begin
      prev_q <= lvl;
    end
  end

  assign fall = prev_q & ~lvl;

endmodule

// File: rtl/sop_shifter.sv
module sop_shifter #(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  input  logic              shift_en,
  input  logic              ser_in,
  output logic [WORD_W-1:0] word_q
);

  logic [WORD_W-1:0] word_d;
  logic              word_en;

  // Load wins over a shift in the same cycle.
  always_comb begin
    word_d = word_q;
    if (load) begin
      word_d = load_word;
    end else if (shift_en) begin
      word_d = {word_q[WORD_W-2:0], ser_in};
    end
  end

  assign word_en = load | shift_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (word_en) begin
      word_q <= word_d;
    end
  end

endmodule

// File: rtl/chain_sout_port.sv
module chain_sout_port
  import sop_pkg::*;
#(
  parameter int WORD_W      = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              sdi,
  input  logic              drdy_n,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  output logic              sdo,
  output logic              sdo_oe
);

  logic             rst_sync_n;
  pin_t             pin_raw;
  logic [PIN_W-1:0] pin_q;
  pin_t             pin_s;
  logic             cs_s;
  logic             sclk_fall;
  logic             shift_en;
  logic [WORD_W-1:0] sh_q;

  sop_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign pin_raw = '{cs_n: cs_n, sclk: sclk, sdi: sdi};

  sop_sync #(
    .W       (PIN_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (PIN_IDLE)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d     (pin_raw),
    .q     (pin_q)
  );

  assign pin_s = pin_t'(pin_q);
  assign cs_s  = pin_s.cs_n;

  sop_fall_det u_fall (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .lvl   (pin_s.sclk),
    .fall  (sclk_fall)
  );

  // A fall only counts while selected and while reading is allowed.
  assign shift_en = sclk_fall & ~cs_s & ~drdy_n;

  sop_shifter #(
    .WORD_W (WORD_W)
  ) u_shift (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .load      (load),
    .load_word (load_word),
    .shift_en  (shift_en),
    .ser_in    (pin_s.sdi),
    .word_q    (sh_q)
  );

  assign sdo_oe = ~cs_s;
  assign sdo    = sdo_oe & sh_q[WORD_W-1];

endmodule

// File: rtl/sop_checker.sv
module sop_checker #(
  parameter int WORD_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              load,
  input logic              load_msb,
  input logic              drdy_n,
  input logic              cs_s,
  input logic [WORD_W-1:0] sh,
  input logic              sdo,
  input logic              sdo_oe
);

  a_r1_shift_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> (sh == $past(sh)) || (sh[WORD_W-1:1] == $past(sh[WORD_W-2:0])));

  a_r5_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !sdo_oe |-> !sdo);

  a_r8_hold_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (drdy_n && !load) |=> $stable(sh));

  a_r9_hold_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_s && !load) |=> $stable(sh));

  a_r10_load_shows_msb: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (!sdo_oe || (sdo == $past(load_msb))));

endmodule

bind chain_sout_port sop_checker #(.WORD_W(WORD_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .load     (load),
  .load_msb (load_word[WORD_W-1]),
  .drdy_n   (drdy_n),
  .cs_s     (cs_s),
  .sh       (sh_q),
  .sdo      (sdo),
  .sdo_oe   (sdo_oe)
);

// File: tb/tb_chain_sout_port.sv
`timescale 1ns/1ps
module tb_chain_sout_port;

  localparam int W = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b1, sdi_pin = 1'b0, drdy_n = 1'b1, load = 1'b0;
  logic chain_en = 1'b0;
  logic [W-1:0] word_a = '0, word_b = '0;
  logic sdo, sdo_oe, sdo_b, sdo_oe_b, sdi_a;
  int vectors = 0, fails = 0, cyc = 0;

  always #10 clk = ~clk;

  assign sdi_a = chain_en ? sdo_b : sdi_pin;

  chain_sout_port dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi_a),
    .drdy_n(drdy_n), .load(load), .load_word(word_a), .sdo(sdo), .sdo_oe(sdo_oe));

  chain_sout_port dut_b (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(1'b0),
    .drdy_n(drdy_n), .load(load), .load_word(word_b), .sdo(sdo_b), .sdo_oe(sdo_oe_b));

  // Behavioural reference for dut: pins seen two edges late, falls one edge after that.
  logic [W-1:0] m_sh;
  logic m_oe;
  logic hc [3], hs [3], hd [3];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sh = '0; m_oe = 1'b0;
      for (int i = 0; i < 3; i++) begin hc[i] = 1'b1; hs[i] = 1'b1; hd[i] = 1'b0; end
    end else begin
      if (load) m_sh = word_a;
      else if (!drdy_n && !hc[1] && !hs[1] && hs[2]) m_sh = {m_sh[W-2:0], hd[1]};
      m_oe = !hc[0];
      for (int i = 2; i > 0; i--) begin hc[i] = hc[i-1]; hs[i] = hs[i-1]; hd[i] = hd[i-1]; end
      hc[0] = cs_n; hs[0] = sclk; hd[0] = sdi_a;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      vectors++;
      if (sdo_oe !== m_oe) begin
        fails++;
        $display("FAIL R5 cycle %0d: sdo_oe=%b expected %b", cyc, sdo_oe, m_oe);
      end
      if (sdo !== (m_oe & m_sh[W-1])) begin
        fails++;
        $display("FAIL R1 cycle %0d: sdo=%b expected %b", cyc, sdo, m_oe & m_sh[W-1]);
      end
    end
  end

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL R1 watchdog: cycle %0d expected below 150000", cyc);
      finish_run();
    end
  end

  task automatic chk(input string req, input logic [71:0] got, input logic [71:0] exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_load();
    @(negedge clk); load = 1'b1;
    @(negedge clk); load = 1'b0;
  endtask

  task automatic fall_once();
    sclk = 1'b0; wait_clk(4);
    sclk = 1'b1; wait_clk(4);
  endtask

  task automatic read_bits(input int n, output logic [71:0] got);
    got = '0;
    for (int i = 0; i < n; i++) begin
      wait_clk(4);
      got = {got[70:0], sdo};
      sclk = 1'b0; wait_clk(4); sclk = 1'b1;
    end
  endtask

  initial begin
    logic [71:0] got;
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(6);

    // R4: reset state
    chk("R4 sdo_oe after reset", {71'd0, sdo_oe}, 72'd0);
    chk("R4 sdo after reset", {71'd0, sdo}, 72'd0);
    drdy_n = 1'b0; cs_n = 1'b0;
    read_bits(W, got);
    chk("R4 register cleared", got, 72'd0);
    cs_n = 1'b1; wait_clk(4);

    // R2, R11: select after data-ready
    word_a = 24'hA5C396;
    drdy_n = 1'b1; pulse_load(); drdy_n = 1'b0; wait_clk(3);
    cs_n = 1'b0;
    wait_clk(1);
    chk("R5 oe one edge after select", {71'd0, sdo_oe}, 72'd0);
    wait_clk(1);
    chk("R2 oe on select", {71'd0, sdo_oe}, 72'd1);
    chk("R2 msb on select", {71'd0, sdo}, {71'd0, word_a[23]});
    sclk = 1'b0;
    wait_clk(2);
    chk("R11 bit held two edges after fall", {71'd0, sdo}, {71'd0, word_a[23]});
    wait_clk(1);
    chk("R11 next bit three edges after fall", {71'd0, sdo}, {71'd0, word_a[22]});
    wait_clk(2); sclk = 1'b1;
    read_bits(W - 1, got);
    chk("R1 remaining bits msb first", got, {49'd0, word_a[22:0]});
    cs_n = 1'b1; wait_clk(3);
    chk("R5 released after deselect", {70'd0, sdo_oe, sdo}, 72'd0);

    // R3: chip select held low
    cs_n = 1'b0; drdy_n = 1'b1; wait_clk(4);
    word_a = 24'h3C0F81;
    pulse_load();
    chk("R3 msb right after load", {71'd0, sdo}, {71'd0, word_a[23]});
    drdy_n = 1'b0;
    read_bits(W, got);
    chk("R3 word with select tied low", got, {48'd0, word_a});

    // R8: falls while data-ready high are ignored
    word_a = 24'hF0E1D2;
    drdy_n = 1'b1; pulse_load();
    for (int i = 0; i < 5; i++) fall_once();
    drdy_n = 1'b0;
    read_bits(W, got);
    chk("R8 falls ignored while not ready", got, {48'd0, word_a});

    // R9: falls while deselected are ignored
    cs_n = 1'b1; wait_clk(4);
    word_a = 24'h5A5A01;
    pulse_load();
    for (int i = 0; i < 5; i++) fall_once();
    cs_n = 1'b0;
    read_bits(W, got);
    chk("R9 falls ignored while deselected", got, {48'd0, word_a});

    // R10: reload mid-read
    word_a = 24'hFFFFFF; pulse_load();
    read_bits(10, got);
    chk("R10 partial read", got, {62'd0, 10'h3FF});
    word_a = 24'h012345; pulse_load();
    read_bits(W, got);
    chk("R10 reload discards old contents", got, {48'd0, word_a});

    // R6, R7: two-port chain
    chain_en = 1'b1;
    word_a = 24'h8ACE13; word_b = 24'hC0FFEE;
    drdy_n = 1'b1; pulse_load(); drdy_n = 1'b0;
    read_bits(3 * W, got);
    chk("R6 chain upstream then downstream word", got[71:24], {word_a, word_b});
    chk("R7 zeros after chain end", got[23:0], 72'd0);
    wait_clk(4);
    chk("R7 sdo low after overrun", {71'd0, sdo}, 72'd0);

    cs_n = 1'b1; wait_clk(6);
    finish_run();
  end

endmodule